// File: doc/BRIEF.md
# Bus Access Enable and Setup Gate

This block sits between a host I/O and memory interface and the register and memory space of a video controller. Each cycle it decides whether the host may reach that space. Several disable sources can shut host access off: an active-low disable pin, disable bits in the block's own control registers, and a disable bit in a global register. The block also tracks whether the controller is in normal mode or setup mode. While setup mode is active, I/O decoding shrinks to one global register at a single fixed port.

A two-bit strap gives the host bus type. On an ISA host, one setup-control register holds the setup request and a local disable bit. On the other bus types, a subsystem-enable register plays that role. On the two bus types that have the external pins, the pins are ORed with the register bits. The block only gates host cycles. It never stops anything else in the controller, so display and memory refresh keep running behind it. Its outputs are a per-cycle register-select code for I/O cycles, a grant for host memory cycles, and read data for its own three control registers.

Top module: `bus_gate`

## Requirements
- R1: After reset, all three control registers read 0 and setup_mode is 0. With both pins high, access_ok is 1.
- R2: access_ok is 0 when any active disable source is set: global register bit 0, the bus-type local disable bit (setup-control bit 1 on ISA, subsystem bit 0 otherwise), or disable_n low on bus types 1 and 2. mem_grant equals mem_req AND access_ok.
- R3: The pins disable_n and setup_n take effect only for bus_kind 1 or 2. They are ignored for bus_kind 0 (ISA) and 3 (local bus).
- R4: The setup-control port is decoded only when bus_kind is 0 (io_sel 1). The subsystem port is decoded only when bus_kind is not 0 (io_sel 2). When a control port is not decoded as a control register, that address is handled like any other address.
- R5: setup_mode is setup-control bit 0 when bus_kind is 0. For the other bus types it is subsystem bit 1, ORed with setup_n low on bus types 1 and 2.
- R6: The global register (io_sel 3) is decoded only in setup mode and only at exactly address 0x102. Aliases such as 0x202 are not decoded, and 0x102 is not decoded in normal mode.
- R7: In setup mode, the video I/O range 0x3B0 to 0x3DF is not decoded (io_sel 0).
- R8: While access_ok is 0, io_sel is never 4 and mem_grant is 0. The control registers stay readable and writable.
- R9: A register write takes effect at the clock edge that ends the write cycle. setup_mode and access_ok keep their old values during the write cycle itself.
- R10: io_rdata_oe is 1 exactly for reads with io_sel 1 to 3, and io_rdata then carries the full stored byte. In every other cycle io_rdata_oe is 0.
- R11: io_sel is 4 for a read or write in 0x3B0 to 0x3DF in normal mode with access allowed. io_sel is 0 whenever neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_kind | input | 2 | Host bus strap: 0 ISA, 1 MC, 2 PI, 3 local |
| disable_n | input | 1 | Active-low external disable |
| setup_n | input | 1 | Active-low external setup request |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| mem_req | input | 1 | Host memory cycle request |
| io_sel | output | 3 | Select: 0 none, 1 setup-control, 2 subsystem, 3 global, 4 video I/O |
| mem_grant | output | 1 | Memory cycle allowed |
| access_ok | output | 1 | No disable source active |
| setup_mode | output | 1 | Setup mode active |
| io_rdata | output | 8 | Control register read data |
| io_rdata_oe | output | 1 | Read data valid |

## Verification
The hardest state to reach is one where the global disable bit is set. That bit can only be cleared through the global port. The global port is only visible in setup mode, and setup mode itself comes from a different register or a pin, depending on the bus type. Directed sequences enter setup mode on ISA, set and clear the global bit, and probe the 0x202 alias. Seeded random traffic then aims writes at the three control ports while the strap and pins change. This drives the block in and out of the combined disabled and setup states, and a bench model tracks the expected registers.

// File: rtl/bus_gate_pkg.sv
package bus_gate_pkg;

    typedef enum logic [1:0] {
        BUS_ISA   = 2'd0,
        BUS_MC    = 2'd1,
        BUS_PI    = 2'd2,
        BUS_LOCAL = 2'd3
    } bus_kind_e;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_SETUP  = 3'd1,
        SEL_SUBSYS = 3'd2,
        SEL_GLOBAL = 3'd3,
        SEL_VIDEO  = 3'd4
    } io_sel_e;

    // number of control registers owned by the gate (select codes 1..N)
    localparam int CTRL_REGS = 3;

    // field positions inside the control registers
    localparam int SETUPREG_REQ_BIT = 0;
    localparam int SETUPREG_OFF_BIT = 1;
    localparam int SUBSYS_OFF_BIT   = 0;
    localparam int SUBSYS_REQ_BIT   = 1;
    localparam int GLOBAL_OFF_BIT   = 0;

    typedef struct packed {
        logic isa_setup;
        logic isa_off;
        logic sub_setup;
        logic sub_off;
        logic glob_off;
    } gate_state_t;

    function automatic logic pins_honored(bus_kind_e kind);
        return (kind == BUS_MC) || (kind == BUS_PI);
    endfunction

    function automatic logic is_ctrl_sel(io_sel_e s);
        return (s == SEL_SETUP) || (s == SEL_SUBSYS) || (s == SEL_GLOBAL);
    endfunction

endpackage

// File: rtl/bus_gate_policy.sv
module bus_gate_policy
    import bus_gate_pkg::*;
(
    input  bus_kind_e   kind,
    input  gate_state_t st,
    input  logic        disable_n,
    input  logic        setup_n,
    output logic        setup_mode,
    output logic        access_ok
);

    logic honored;
    logic local_off;

    always_comb begin
        honored = pins_honored(kind);
        if (kind == BUS_ISA) begin
            setup_mode = st.isa_setup;
            local_off  = st.isa_off;
        end else begin
            setup_mode = st.sub_setup | (honored & ~setup_n);
            local_off  = st.sub_off   | (honored & ~disable_n);
        end
        access_ok = ~(st.glob_off | local_off);
    end

endmodule

// File: rtl/bus_gate_decode.sv
module bus_gate_decode
    import bus_gate_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] SETUP_PORT  = 16'h046E,
    parameter logic [ADDR_W-1:0] SUBSYS_PORT = 16'h03C3,
    parameter logic [ADDR_W-1:0] GLOBAL_PORT = 16'h0102,
    parameter logic [ADDR_W-1:0] VIDEO_LO    = 16'h03B0,
    parameter logic [ADDR_W-1:0] VIDEO_HI    = 16'h03DF
) (
    input  bus_kind_e          kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  logic               wr,
    input  logic               setup_mode,
    input  logic               access_ok,
    output io_sel_e            sel
);

    logic strobe;
    logic in_video;
    logic hit_setup;
    logic hit_subsys;
    logic hit_global;

    always_comb begin
        strobe     = rd | wr;
        in_video   = (addr >= VIDEO_LO) && (addr <= VIDEO_HI);
        hit_setup  = (kind == BUS_ISA) && (addr == SETUP_PORT);
        hit_subsys = (kind != BUS_ISA) && (addr == SUBSYS_PORT);
        hit_global = setup_mode && (addr == GLOBAL_PORT);

        sel = SEL_NONE;
        if (strobe) begin
            if (hit_setup)
                sel = SEL_SETUP;
            else if (hit_subsys)
                sel = SEL_SUBSYS;
            else if (hit_global)
                sel = SEL_GLOBAL;
            else if (!setup_mode && access_ok && in_video)
                sel = SEL_VIDEO;
        end
    end

endmodule

// File: rtl/bus_gate_regs.sv
module bus_gate_regs
    import bus_gate_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  io_sel_e           sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output gate_state_t       st,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    logic [DATA_W-1:0] regs [CTRL_REGS];

    for (genvar i = 0; i < CTRL_REGS; i++) begin : g_reg
        localparam logic [2:0] CODE = 3'(i + 1);
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr && (sel == io_sel_e'(CODE)))
                regs[i] <= wdata;
        end
    end

    always_comb begin
        st.isa_setup = regs[0][SETUPREG_REQ_BIT];
        st.isa_off   = regs[0][SETUPREG_OFF_BIT];
        st.sub_off   = regs[1][SUBSYS_OFF_BIT];
        st.sub_setup = regs[1][SUBSYS_REQ_BIT];
        st.glob_off  = regs[2][GLOBAL_OFF_BIT];
    end

    always_comb begin
        rdata_oe = rd && is_ctrl_sel(sel);
        rdata    = '0;
        if (rdata_oe) begin
            case (sel)
                SEL_SETUP:  rdata = regs[0];
                SEL_SUBSYS: rdata = regs[1];
                default:    rdata = regs[2];
            endcase
        end
    end

endmodule

// File: rtl/bus_gate.sv
module bus_gate
    import bus_gate_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] SETUP_PORT  = 16'h046E,
    parameter logic [ADDR_W-1:0] SUBSYS_PORT = 16'h03C3,
    parameter logic [ADDR_W-1:0] GLOBAL_PORT = 16'h0102,
    parameter logic [ADDR_W-1:0] VIDEO_LO    = 16'h03B0,
    parameter logic [ADDR_W-1:0] VIDEO_HI    = 16'h03DF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_kind,
    input  logic              disable_n,
    input  logic              setup_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              mem_req,
    output logic [2:0]        io_sel,
    output logic              mem_grant,
    output logic              access_ok,
    output logic              setup_mode,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rdata_oe
);

    bus_kind_e   kind;
    gate_state_t st;
    io_sel_e     sel;
    logic        mode_setup;
    logic        ok;

    assign kind = bus_kind_e'(bus_kind);

    bus_gate_policy u_policy (
        .kind       (kind),
        .st         (st),
        .disable_n  (disable_n),
        .setup_n    (setup_n),
        .setup_mode (mode_setup),
        .access_ok  (ok)
    );

    bus_gate_decode #(
        .ADDR_W      (ADDR_W),
        .SETUP_PORT  (SETUP_PORT),
        .SUBSYS_PORT (SUBSYS_PORT),
        .GLOBAL_PORT (GLOBAL_PORT),
        .VIDEO_LO    (VIDEO_LO),
        .VIDEO_HI    (VIDEO_HI)
    ) u_decode (
        .kind       (kind),
        .addr       (io_addr),
        .rd         (io_rd),
        .wr         (io_wr),
        .setup_mode (mode_setup),
        .access_ok  (ok),
        .sel        (sel)
    );

    bus_gate_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .rd       (io_rd),
        .wr       (io_wr),
        .wdata    (io_wdata),
        .st       (st),
        .rdata    (io_rdata),
        .rdata_oe (io_rdata_oe)
    );

    assign io_sel     = sel;
    assign access_ok  = ok;
    assign setup_mode = mode_setup;
    assign mem_grant  = mem_req & ok;

endmodule

// File: rtl/bus_gate_checker.sv
module bus_gate_checker #(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] GLOBAL_PORT = 16'h0102
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_kind,
    input logic              setup_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              mem_grant,
    input logic              access_ok,
    input logic              setup_mode,
    input logic [2:0]        io_sel,
    input logic              io_rdata_oe
);

    assert_grant_R2: assert property (@(posedge clk) disable iff (rst)
        mem_grant |-> access_ok);

    assert_global_exact_R6: assert property (@(posedge clk) disable iff (rst)
        (io_sel == 3'd3) |-> (setup_mode && io_addr == GLOBAL_PORT));

    assert_setup_no_video_R7: assert property (@(posedge clk) disable iff (rst)
        setup_mode |-> (io_sel != 3'd4));

    assert_off_no_video_R8: assert property (@(posedge clk) disable iff (rst)
        !access_ok |-> (io_sel != 3'd4 && !mem_grant));

    assert_mode_after_write_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(setup_mode) && $stable(bus_kind) && $stable(setup_n)) |-> $past(io_wr));

    assert_oe_on_read_R10: assert property (@(posedge clk) disable iff (rst)
        io_rdata_oe |-> (io_rd && io_sel != 3'd0 && io_sel != 3'd4));

    assert_idle_none_R11: assert property (@(posedge clk) disable iff (rst)
        (!io_rd && !io_wr) |-> (io_sel == 3'd0));

endmodule

bind bus_gate bus_gate_checker u_chk (.*);

// File: tb/bus_gate_tb.sv
module bus_gate_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] P_SETUP  = 16'h046E;
    localparam logic [15:0] P_SUBSYS = 16'h03C3;
    localparam logic [15:0] P_GLOBAL = 16'h0102;

    logic        clk = 0;
    logic        rst;
    logic [1:0]  bus_kind;
    logic        disable_n, setup_n;
    logic [15:0] io_addr;
    logic        io_rd, io_wr, mem_req;
    logic [7:0]  io_wdata;
    logic [2:0]  io_sel;
    logic        mem_grant, access_ok, setup_mode, io_rdata_oe;
    logic [7:0]  io_rdata;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_setup, m_sub, m_glob;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_gate u_dut (
        .clk(clk), .rst(rst), .bus_kind(bus_kind), .disable_n(disable_n),
        .setup_n(setup_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .mem_req(mem_req), .io_sel(io_sel),
        .mem_grant(mem_grant), .access_ok(access_ok), .setup_mode(setup_mode),
        .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe)
    );

    function automatic logic exp_setup();
        if (bus_kind == 2'd0) return m_setup[0];
        return m_sub[1] | ((bus_kind == 2'd1 || bus_kind == 2'd2) & ~setup_n);
    endfunction

    function automatic logic exp_ok();
        logic off;
        if (bus_kind == 2'd0) off = m_setup[1];
        else off = m_sub[0] | ((bus_kind == 2'd1 || bus_kind == 2'd2) & ~disable_n);
        return ~(m_glob[0] | off);
    endfunction

    function automatic logic [2:0] exp_sel();
        if (!(io_rd || io_wr)) return 3'd0;
        if (bus_kind == 2'd0 && io_addr == P_SETUP) return 3'd1;
        if (bus_kind != 2'd0 && io_addr == P_SUBSYS) return 3'd2;
        if (exp_setup() && io_addr == P_GLOBAL) return 3'd3;
        if (!exp_setup() && exp_ok() && io_addr >= 16'h03B0 && io_addr <= 16'h03DF)
            return 3'd4;
        return 3'd0;
    endfunction

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // One host cycle: drive at negedge, check outputs, update model at posedge.
    task automatic cycle(string tag, logic [1:0] kind, logic dn, logic sn,
                         logic [15:0] addr, logic rd, logic wr, logic [7:0] wd, logic mr);
        logic [2:0] es;
        logic       eoe;
        logic [7:0] erd;
        @(negedge clk);
        bus_kind = kind; disable_n = dn; setup_n = sn;
        io_addr = addr; io_rd = rd; io_wr = wr; io_wdata = wd; mem_req = mr;
        #1;
        es  = exp_sel();
        eoe = rd && (es >= 3'd1 && es <= 3'd3);
        erd = (es == 3'd1) ? m_setup : (es == 3'd2) ? m_sub : m_glob;
        check((tag != "") ? tag : "R5", "setup_mode", setup_mode, exp_setup());
        check((tag != "") ? tag : "R2", "access_ok", access_ok, exp_ok());
        check((tag != "") ? tag : (exp_ok() ? "R2" : "R8"), "mem_grant", mem_grant, mr & exp_ok());
        check((tag != "") ? tag : (exp_setup() ? "R7" : (!exp_ok() ? "R8" : "R11")),
              "io_sel", io_sel, es);
        check((tag != "") ? tag : "R10", "io_rdata_oe", io_rdata_oe, eoe);
        if (eoe) check((tag != "") ? tag : "R10", "io_rdata", io_rdata, erd);
        @(posedge clk);
        if (wr) begin
            if (es == 3'd1) m_setup = wd;
            else if (es == 3'd2) m_sub = wd;
            else if (es == 3'd3) m_glob = wd;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; bus_kind = 0; disable_n = 1; setup_n = 1; io_addr = 0;
        io_rd = 0; io_wr = 0; io_wdata = 0; mem_req = 0;
        m_setup = 0; m_sub = 0; m_glob = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        cycle("R1", 2'd0, 1, 1, 16'h0000, 0, 0, 8'h00, 1);
        cycle("R1", 2'd0, 1, 1, P_SETUP, 1, 0, 8'h00, 0);
        check("R1", "setup reg read", io_rdata, 0);
        cycle("R1", 2'd1, 1, 1, P_SUBSYS, 1, 0, 8'h00, 0);
        check("R1", "subsys reg read", io_rdata, 0);

        // R3 pins only for MC/PI
        cycle("R3", 2'd0, 0, 0, 16'h03C0, 1, 0, 8'h00, 1);
        cycle("R3", 2'd3, 0, 0, 16'h03C0, 1, 0, 8'h00, 1);
        check("R3", "local bus ok", access_ok, 1);
        cycle("R3", 2'd1, 0, 1, 16'h03C0, 1, 0, 8'h00, 1);
        check("R3", "MC pin disables", access_ok, 0);
        cycle("R3", 2'd2, 1, 0, 16'h03C0, 1, 0, 8'h00, 0);
        check("R3", "PI pin setup", setup_mode, 1);

        // R4 control port visibility per bus type
        cycle("R4", 2'd0, 1, 1, P_SUBSYS, 1, 0, 8'h00, 0);
        check("R4", "ISA subsys port is video", io_sel, 4);
        cycle("R4", 2'd3, 1, 1, P_SETUP, 1, 0, 8'h00, 0);
        check("R4", "local setup port unmapped", io_sel, 0);

        // R9 write timing, enter setup on ISA
        cycle("R9", 2'd0, 1, 1, P_SETUP, 0, 1, 8'h01, 0);
        check("R9", "setup_mode during write", setup_mode, 0);
        cycle("R9", 2'd0, 1, 1, 16'h0000, 0, 0, 8'h00, 0);
        check("R9", "setup_mode after write", setup_mode, 1);

        // R6/R7 in setup mode
        cycle("R6", 2'd0, 1, 1, P_GLOBAL, 1, 0, 8'h00, 0);
        check("R6", "global decoded", io_sel, 3);
        cycle("R6", 2'd0, 1, 1, 16'h0202, 1, 0, 8'h00, 0);
        check("R6", "alias not decoded", io_sel, 0);
        cycle("R7", 2'd0, 1, 1, 16'h03D4, 1, 0, 8'h00, 0);
        check("R7", "video hidden in setup", io_sel, 0);

        // R8 global disable, still reachable
        cycle("R8", 2'd0, 1, 1, P_GLOBAL, 0, 1, 8'hA5, 0);
        cycle("R8", 2'd0, 1, 1, P_GLOBAL, 1, 0, 8'h00, 1);
        check("R8", "global readback", io_rdata, 8'hA5);
        check("R8", "mem blocked", mem_grant, 0);
        cycle("R8", 2'd0, 1, 1, P_GLOBAL, 0, 1, 8'h00, 0);
        cycle("R6", 2'd0, 1, 1, P_SETUP, 0, 1, 8'h00, 0);
        cycle("R6", 2'd0, 1, 1, P_GLOBAL, 1, 0, 8'h00, 0);
        check("R6", "global hidden in normal", io_sel, 0);
        cycle("R11", 2'd0, 1, 1, 16'h03D4, 1, 0, 8'h00, 1);
        check("R11", "video decoded", io_sel, 4);

        // R8 subsystem disable and recovery
        cycle("R8", 2'd1, 1, 1, P_SUBSYS, 0, 1, 8'h01, 0);
        cycle("R8", 2'd1, 1, 1, 16'h03D4, 1, 0, 8'h00, 1);
        check("R8", "video blocked", io_sel, 0);
        cycle("R8", 2'd1, 1, 1, P_SUBSYS, 0, 1, 8'h00, 0);
        cycle("R8", 2'd1, 1, 1, 16'h03D4, 0, 1, 8'h00, 1);
        check("R8", "re-enabled", io_sel, 4);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            logic [1:0]  k;
            logic        r, w;
            logic [7:0]  d;
            case ($urandom_range(0, 6))
                0: a = P_SETUP;
                1: a = P_SUBSYS;
                2: a = P_GLOBAL;
                3: a = 16'h0202;
                4: a = 16'h03B0 + 16'($urandom_range(0, 16'h2F));
                5: a = 16'h03A0 + 16'($urandom_range(0, 16'h4F));
                default: a = 16'($urandom);
            endcase
            k = 2'($urandom_range(0, 3));
            r = 1'b0; w = 1'b0;
            case ($urandom_range(0, 2))
                0: r = 1'b1;
                1: w = 1'b1;
                default: ;
            endcase
            d = 8'($urandom);
            if ($urandom_range(0, 1) == 0) d[1:0] = 2'b00;
            cycle("", k, ($urandom_range(0, 4) != 0), ($urandom_range(0, 4) != 0),
                  a, r, w, d, 1'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule